// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks one of several free-running source clocks and forwards it as a single output clock. The selection can change at any moment, even while every source is running. A change never produces a shortened high or low phase at the output. Each source has its own gate, and that gate only opens or closes while its source clock is low.

A switch runs in two steps. First the gate of the source that is driving the output closes in that source's own domain. Then the gate of the requested source opens in its own domain, but only after that lane has seen every other gate closed through its own two-flop path. Between the two steps the output stays low.

A one-hot status vector shows which source is driving the output. It reads all zeros while a switch is in progress, so software can poll it to see when a switch is complete. When the block is built with a single source, nothing is switched: the output is that source and the status is the constant 1.

Top module: `clk_glitchfree_mux`

## Requirements
- R1: While status bit i is set, `clk_o` equals `clk_src_i[i]`. No high or low phase of `clk_o` is shorter than the shorter half-period of the old and new source of the most recent switch.
- R2: When the select value changes to a different source, the status passes through all zeros before the new bit is set. Writing the value that is already selected never clears the status.
- R3: At most one bit of `active_o` is set at any time after reset.
- R4: A set status bit means that source's gate is open, and no other gate is open at the same time.
- R5: A source that is no longer selected closes its gate, and clears its status bit, by the second falling edge of its own clock after the select value moves away from it.
- R6: After a switch request, the new source's status bit sets (`active_o == 1 << sel_i`) only after all other gates are seen closed, and `clk_o` then follows that source.
- R7: While `rst_ni` is low, `active_o` is 0 and `clk_o` is low. After reset is released with `sel_i` = 0, `active_o` becomes 4'b0001 (bit 0 = source 0) once source 0's gate has synchronised.
- R8: With `N_SRC` = 1, `active_o` is the constant 1'b1 and `clk_o` equals `clk_src_i[0]`, whatever the reset state.
- R9: If the select value is rewritten while a switch is still closing the old gate, the block settles on the last value written, and the intermediate source never drives the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | N_SRC | Source clocks; bit i is source i |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised per source |
| sel_i | input | SEL_W | Index of the requested source (SEL_W = clog2(N_SRC), minimum 1) |
| clk_o | output | 1 | Forwarded clock |
| active_o | output | N_SRC | One-hot status of the source driving `clk_o`; all zeros during a switch |

## Verification
The exclusion and drop-timing assertions assume one thing about `sel_i`: it is not moved between two different new sources at a time when the old gate is already closed. If it were, two lanes could each see the others closed and both capture a request. The stimulus therefore changes `sel_i` just after a rising edge of source 0. It starts the next switch only once the status has settled, and the one back-to-back rewrite is issued within a few nanoseconds, while the old gate is still open. Under that rule, phase lengths are checked against the old and new half-periods of each switch. The source periods are chosen to be mutually unrelated, so that the gate edges fall at varied points of each source's cycle.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

  // Width of a source index; a single-source build still carries one bit.
  function automatic int sel_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Per-lane gating state: captured request, then the gate itself.
  typedef struct packed {
    logic req;
    logic en;
  } gate_state_t;

endpackage

// File: rtl/gcs_rst_sync.sv
module gcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/gcs_lane.sv
module gcs_lane
  import gcs_pkg::*;
#(
  parameter int N_SRC      = 4,
  parameter int IDX        = 0,
  parameter int SEL_W      = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_SRC-1:0] en_all_i,
  output logic             en_o,
  output logic             gclk_o
);

  localparam logic [N_SRC-1:0] SELF_MASK = N_SRC'(1) << IDX;
  localparam logic [SEL_W-1:0] MY_CODE   = SEL_W'(IDX);

  logic             rst_q;
  logic [N_SRC-1:0] others;
  logic             want;
  gate_state_t      st_q;
  gate_state_t      st_d;

  gcs_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_q)
  );

  // Request only when selected and every other gate is seen closed.
  always_comb begin
    others  = en_all_i & ~SELF_MASK;
    want    = (sel_i == MY_CODE) && (others == '0);
    st_d.req = want;
    st_d.en  = st_q.req;
  end

  // Falling-edge flops: the gate moves only while this clock is low.
  always_ff @(negedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign en_o   = st_q.en;
  assign gclk_o = clk_i & st_q.en;

  // R4: an open gate never coexists with another open gate
  a_r4_exclusive: assert property (@(negedge clk_i) disable iff (!rst_q)
    st_q.en |-> (others == '0));

  // R5: deselection closes the gate by the second falling edge
  a_r5_drop: assert property (@(negedge clk_i) disable iff (!rst_q)
    (sel_i != MY_CODE) |-> ##2 !st_q.en);

endmodule

// File: rtl/clk_glitchfree_mux.sv
module clk_glitchfree_mux
  import gcs_pkg::*;
#(
  parameter int  N_SRC      = 4,
  parameter int  RST_STAGES = 2,
  localparam int SEL_W      = sel_width(N_SRC)
) (
  input  logic [N_SRC-1:0] clk_src_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o,
  output logic [N_SRC-1:0] active_o
);

  generate
    if (N_SRC == 1) begin : g_single
      logic unused_inputs;
      assign unused_inputs = ^sel_i ^ rst_ni;
      assign clk_o    = clk_src_i[0];
      assign active_o = 1'b1;
    end else begin : g_multi
      logic [N_SRC-1:0] en_all;
      logic [N_SRC-1:0] gated;

      for (genvar gi = 0; gi < N_SRC; gi++) begin : g_lane
        gcs_lane #(
          .N_SRC      (N_SRC),
          .IDX        (gi),
          .SEL_W      (SEL_W),
          .RST_STAGES (RST_STAGES)
        ) u_lane (
          .clk_i    (clk_src_i[gi]),
          .arst_ni  (rst_ni),
          .sel_i    (sel_i),
          .en_all_i (en_all),
          .en_o     (en_all[gi]),
          .gclk_o   (gated[gi])
        );
      end

      assign clk_o    = |gated;
      assign active_o = en_all;

      // R3: status never shows two sources at once
      always_comb begin
        if (rst_ni === 1'b1) begin
          a_r3_onehot: assert ($onehot0(active_o));
        end
      end

      // R7: reset holds every gate closed
      a_r7_reset_idle: assert property (@(posedge clk_src_i[0])
        !rst_ni |-> (active_o == '0));
    end
  endgenerate

endmodule

// File: tb/clk_glitchfree_mux_tb_top.sv
`timescale 1ns/1ps
module clk_glitchfree_mux_tb_top;

  typedef struct {
    int    src;
    int    gap_mode;   // 0: no gap allowed, 1: gap required, 2: don't care
    string tag;
  } exp_item_t;

  logic       clk;
  logic [3:0] clk_src;
  logic       rst_n;
  logic [1:0] sel;
  logic       clk_o;
  logic [3:0] active;
  logic       s_clk_o;
  logic [0:0] s_active;
  logic [0:0] s_sel;

  real half [4] = '{10.0, 7.0, 13.0, 17.0};

  int n_chk = 0;
  int n_fail = 0;
  int cur = 0;
  int chk_idx = 0;
  int oh_bad = 0;
  int phase_bad = 0;
  bit saw_zero = 0;
  bit mon_busy = 0;
  bit run_started = 0;
  bit done = 0;
  real min_ok = 10.0;
  real last_t = 0.0;
  bit have_edge = 0;
  exp_item_t exp_q[$];

  // 50 MHz bench clock doubles as source 0
  initial clk = 1'b0;
  always #10 clk = ~clk;
  initial begin clk_src[1] = 1'b0; forever #7  clk_src[1] = ~clk_src[1]; end
  initial begin clk_src[2] = 1'b0; forever #13 clk_src[2] = ~clk_src[2]; end
  initial begin clk_src[3] = 1'b0; forever #17 clk_src[3] = ~clk_src[3]; end
  assign clk_src[0] = clk;

  wire mon_clk = clk_src[chk_idx];

  clk_glitchfree_mux #(.N_SRC(4)) dut_i (
    .clk_src_i (clk_src),
    .rst_ni    (rst_n),
    .sel_i     (sel),
    .clk_o     (clk_o),
    .active_o  (active)
  );

  clk_glitchfree_mux #(.N_SRC(1)) single_i (
    .clk_src_i (clk),
    .rst_ni    (rst_n),
    .sel_i     (s_sel),
    .clk_o     (s_clk_o),
    .active_o  (s_active)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // continuous monitors
  always @(active) begin
    if (active == 4'b0000) saw_zero = 1;
    if (run_started && !$onehot0(active)) oh_bad++;
  end

  always @(clk_o) begin
    if (have_edge && (($realtime - last_t) < (min_ok - 0.01))) phase_bad++;
    last_t = $realtime;
    have_edge = 1;
  end

  // scoreboard monitor
  initial begin
    forever begin
      exp_item_t it;
      int waited;
      int mism;
      logic [3:0] want;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      mon_busy = 1;
      want = 4'(1 << it.src);
      waited = 0;
      while (active !== want && waited < 4000) begin
        #1;
        waited++;
      end
      check(active === want, it.tag, "status after switch", int'(active), int'(want));
      if (it.gap_mode == 1)
        check(saw_zero, "R2", "all-zero gap seen", int'(saw_zero), 1);
      else if (it.gap_mode == 0)
        check(!saw_zero, "R2", "no gap on same select", int'(saw_zero), 0);
      chk_idx = it.src;
      #1;
      mism = 0;
      for (int k = 0; k < 6; k++) begin
        @(posedge mon_clk); #1;
        if (clk_o !== 1'b1) mism++;
        @(negedge mon_clk); #1;
        if (clk_o !== 1'b0) mism++;
      end
      check(mism == 0, "R1", "output follows selected source", mism, 0);
      mon_busy = 0;
    end
  end

  // driver
  task automatic do_select(input int v, input string tag);
    exp_item_t it;
    int old;
    old = cur;
    @(posedge clk); #1;
    min_ok = (half[old] < half[v]) ? half[old] : half[v];
    saw_zero = 0;
    sel = 2'(v);
    it.src = v;
    it.gap_mode = (v != old) ? 1 : 0;
    it.tag = tag;
    exp_q.push_back(it);
    if (v != old) begin
      #(4.0 * half[old] + 1.0);
      check(active[old] === 1'b0, "R5", "old status cleared in two falling edges",
            int'(active[old]), 0);
    end
    wait (exp_q.size() == 0);
    wait (mon_busy == 0);
    cur = v;
  endtask

  task automatic do_rewrite(input int first, input int last);
    exp_item_t it;
    @(posedge clk); #1;
    min_ok = 7.0;
    saw_zero = 0;
    sel = 2'(first);
    #3;
    sel = 2'(last);
    it.src = last;
    it.gap_mode = 1;
    it.tag = "R9";
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    wait (mon_busy == 0);
    cur = last;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    exp_item_t it;
    int mism;
    rst_n = 1'b0;
    sel = 2'd0;
    s_sel = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(active === 4'b0000, "R7", "status in reset", int'(active), 0);
    check(clk_o === 1'b0, "R7", "output low in reset", int'(clk_o), 0);
    check(s_active === 1'b1, "R8", "single-source status in reset", int'(s_active), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_started = 1;
    it.src = 0;
    it.gap_mode = 2;
    it.tag = "R7";
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    wait (mon_busy == 0);

    // R8: single-source build
    mism = 0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      if (s_clk_o !== 1'b1 || s_active !== 1'b1) mism++;
      @(negedge clk); #1;
      if (s_clk_o !== 1'b0 || s_active !== 1'b1) mism++;
    end
    check(mism == 0, "R8", "single-source passthrough", mism, 0);

    do_select(2, "R6");
    do_select(1, "R6");
    do_select(3, "R6");
    do_select(0, "R6");
    do_select(3, "R6");
    do_select(3, "R6");   // same value: no gap (R2)
    do_select(0, "R6");
    do_rewrite(1, 3);     // R9: rewrite while old gate still open
    do_select(2, "R6");

    check(oh_bad == 0, "R3", "one-hot violations", oh_bad, 0);
    check(phase_bad == 0, "R1", "short output phases", phase_bad, 0);
    finish_run();
  end

endmodule